// File: doc/BRIEF.md
# Interleaved Address Target Selector

This block sits at a host bridge or a switch upstream port and answers one question for each request: which downstream port owns a given host physical address. It holds no registers of its own for the address windows. The per-slot base, size, control and target-list words come in as inputs, laid out as they would be held in a decoder register file. The block scans those slots, finds the window that covers the address, and resolves the interleave position inside that window to an 8-bit port identifier.

The slots are examined in a fixed priority order. The lowest-numbered slot whose window contains the address decides the outcome. If that slot is not committed, or its way encoding is unsupported, the answer is "not found", even when a later slot would also cover the address. Inside the deciding slot, the address is shifted right by the granularity and reduced modulo the way count. The resulting index picks one byte from the two target-list words. The answer is registered: it appears one clock after the request strobe.

Top module: `ileave_target_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid`, `rsp_found` and `rsp_target` are all zero.
- R2: A slot covers an address when base <= address < base + size, compared without wrap-around. A slot with size 0 covers nothing.
- R3: Base and size are each formed as {high word, low word bits [31:28], 28 zero bits}. Low-word bits [27:0] have no effect on the result.
- R4: The interleave index is (address >> (8 + IG)) modulo 2^IW. IG is control bits [3:0] and IW is control bits [7:4].
- R5: Index values 0 to 3 select byte `idx` (bits idx*8+7 : idx*8) of the low target-list word. Index values 4 to 7 select byte `idx-4` of the high target-list word.
- R6: When several slots cover the address, the lowest-numbered slot decides the result.
- R7: If the deciding slot has its committed flag (control bit 8) clear, the result is not-found, and later slots are not consulted.
- R8: If the deciding slot is committed but IW is greater than 3, the result is not-found.
- R9: When no slot covers the address, `rsp_found` is 0. Whenever `rsp_found` is 0, `rsp_target` is 0.
- R10: `rsp_valid` is high exactly in the cycle after `req_valid` was high. In a cycle without `rsp_valid`, both `rsp_found` and `rsp_target` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | Host physical address to resolve |
| slot_base_hi | input | NUM_SLOTS*32 | Base high words, slot i at [i*32 +: 32] |
| slot_base_lo | input | NUM_SLOTS*32 | Base low words, only bits [31:28] used |
| slot_size_hi | input | NUM_SLOTS*32 | Size high words |
| slot_size_lo | input | NUM_SLOTS*32 | Size low words, only bits [31:28] used |
| slot_ctrl | input | NUM_SLOTS*32 | Control words: IG [3:0], IW [7:4], committed [8] |
| slot_tgt_lo | input | NUM_SLOTS*32 | Target IDs for indices 0 to 3, one per byte |
| slot_tgt_hi | input | NUM_SLOTS*32 | Target IDs for indices 4 to 7, one per byte |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_found | output | 1 | A committed, supported slot resolved the address |
| rsp_target | output | 8 | Selected downstream port identifier |

## Verification
The assertions check the response timing and the zeroing rules on every cycle:
- a response follows every request one cycle later, and only then;
- there is no found flag outside a response;
- the target is zero whenever the found flag is low.

Window arithmetic, slot priority, the uncommitted-first-match cutoff, masking of the low words and the byte chosen for each interleave index can only be shown by scenarios. The bench covers these with directed boundary addresses, overlapping windows and randomized slot sets, compared against a behavioural model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int ADDR_W     = 64;
    localparam int WORD_W     = 32;
    localparam int TID_W      = 8;
    localparam int IG_W       = 4;
    localparam int IW_W       = 4;
    localparam int IG_LSB     = 0;
    localparam int IW_LSB     = 4;
    localparam int COMMIT_BIT = 8;
    localparam int MAX_IW     = 3;
    localparam int GRAN_SHIFT = 8;
    localparam int KEEP_LO    = 4;
    localparam int DROP_LO    = WORD_W - KEEP_LO;
    localparam int IDX_W      = MAX_IW;
    localparam int TIDS_PER_W = WORD_W / TID_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic [IG_W-1:0]   ig;
        logic [IW_W-1:0]   iw;
        logic              committed;
        logic [WORD_W-1:0] tgt_lo;
        logic [WORD_W-1:0] tgt_hi;
    } slot_cfg_t;

    typedef struct packed {
        logic             found;
        logic [TID_W-1:0] target;
    } tsel_rsp_t;

    function automatic logic [ADDR_W-1:0] join_words(input logic [WORD_W-1:0] hi,
                                                     input logic [WORD_W-1:0] lo);
        return {hi, lo[WORD_W-1 -: KEEP_LO], {DROP_LO{1'b0}}};
    endfunction

    function automatic logic [IDX_W-1:0] way_mask(input logic [IW_W-1:0] iw);
        logic [IDX_W-1:0] m;
        m = '0;
        for (int b = 0; b < IDX_W; b++) begin
            if (int'(iw) > b) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tsel_range_match.sv
module tsel_range_match
    import tsel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    output logic              hit
);
    logic [ADDR_W:0] limit;
    logic            above_base;
    logic            below_limit;

    always_comb begin
        limit       = {1'b0, base} + {1'b0, size};
        above_base  = ({1'b0, addr} >= {1'b0, base});
        below_limit = ({1'b0, addr} < limit);
        hit         = above_base && below_limit;
    end
endmodule

// File: rtl/tsel_first_hit.sv
module tsel_first_hit #(
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] hits,
    output logic                 any_hit,
    output logic [SEL_W-1:0]     sel
);
    always_comb begin
        any_hit = |hits;
        sel     = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hits[i]) sel = SEL_W'(i);
        end
    end
endmodule

// File: rtl/tsel_target_pick.sv
module tsel_target_pick
    import tsel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  slot_cfg_t         cfg,
    output logic              usable,
    output logic [TID_W-1:0]  target
);
    logic [ADDR_W-1:0] shifted;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        byte_sel;
    logic [WORD_W-1:0] word;

    always_comb begin
        shifted  = addr >> (GRAN_SHIFT + int'(cfg.ig));
        idx      = shifted[IDX_W-1:0] & way_mask(cfg.iw);
        word     = idx[IDX_W-1] ? cfg.tgt_hi : cfg.tgt_lo;
        byte_sel = idx[1:0];
        target   = word[byte_sel*TID_W +: TID_W];
        usable   = cfg.committed && (int'(cfg.iw) <= MAX_IW);
    end
endmodule

// File: rtl/ileave_target_sel.sv
module ileave_target_sel
    import tsel_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int BUS_W = NUM_SLOTS * WORD_W,
    localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  slot_base_hi,
    input  logic [BUS_W-1:0]  slot_base_lo,
    input  logic [BUS_W-1:0]  slot_size_hi,
    input  logic [BUS_W-1:0]  slot_size_lo,
    input  logic [BUS_W-1:0]  slot_ctrl,
    input  logic [BUS_W-1:0]  slot_tgt_lo,
    input  logic [BUS_W-1:0]  slot_tgt_hi,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic [TID_W-1:0]  rsp_target
);
    slot_cfg_t          cfg [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hits;
    logic               any_hit;
    logic [SEL_W-1:0]   sel;
    slot_cfg_t          chosen;
    logic               usable;
    logic [TID_W-1:0]   pick;
    tsel_rsp_t          rsp_d;
    tsel_rsp_t          rsp_q;
    logic               valid_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [WORD_W-1:0] ctrl_w;
        always_comb begin
            ctrl_w            = slot_ctrl[s*WORD_W +: WORD_W];
            cfg[s].base       = join_words(slot_base_hi[s*WORD_W +: WORD_W],
                                           slot_base_lo[s*WORD_W +: WORD_W]);
            cfg[s].size       = join_words(slot_size_hi[s*WORD_W +: WORD_W],
                                           slot_size_lo[s*WORD_W +: WORD_W]);
            cfg[s].ig         = ctrl_w[IG_LSB +: IG_W];
            cfg[s].iw         = ctrl_w[IW_LSB +: IW_W];
            cfg[s].committed  = ctrl_w[COMMIT_BIT];
            cfg[s].tgt_lo     = slot_tgt_lo[s*WORD_W +: WORD_W];
            cfg[s].tgt_hi     = slot_tgt_hi[s*WORD_W +: WORD_W];
        end

        tsel_range_match i_match (
            .addr (req_addr),
            .base (cfg[s].base),
            .size (cfg[s].size),
            .hit  (hits[s])
        );
    end

    tsel_first_hit #(.NUM_SLOTS(NUM_SLOTS)) i_first (
        .hits    (hits),
        .any_hit (any_hit),
        .sel     (sel)
    );

    always_comb begin
        chosen = cfg[0];
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel == SEL_W'(i)) chosen = cfg[i];
        end
    end

    tsel_target_pick i_pick (
        .addr   (req_addr),
        .cfg    (chosen),
        .usable (usable),
        .target (pick)
    );

    always_comb begin
        rsp_d.found  = req_valid && any_hit && usable;
        rsp_d.target = rsp_d.found ? pick : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= req_valid;
            rsp_q   <= rsp_d;
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_found  = rsp_q.found;
    assign rsp_target = rsp_q.target;
endmodule

// File: rtl/ileave_target_sel_chk.sv
module ileave_target_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       rsp_valid,
    input logic       rsp_found,
    input logic [7:0] rsp_target
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_found && rsp_target == 8'd0));

    // R9
    miss_zero_target_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_found |-> (rsp_target == 8'd0));
endmodule

bind ileave_target_sel ileave_target_sel_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_found  (rsp_found),
    .rsp_target (rsp_target)
);

// File: tb/test_ileave_target_sel.sv
module test_ileave_target_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [31:0] b_hi [NS];
    logic [31:0] b_lo [NS];
    logic [31:0] s_hi [NS];
    logic [31:0] s_lo [NS];
    logic [31:0] ctl  [NS];
    logic [31:0] t_lo [NS];
    logic [31:0] t_hi [NS];
    logic [NS*32-1:0] v_bh, v_bl, v_sh, v_sl, v_ct, v_tl, v_th;
    logic rsp_valid, rsp_found;
    logic [7:0] rsp_target;

    int checks = 0;
    int fails = 0;
    logic exp_valid = 1'b0, exp_found = 1'b0;
    logic [7:0] exp_target = '0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            v_bh[i*32 +: 32] = b_hi[i];
            v_bl[i*32 +: 32] = b_lo[i];
            v_sh[i*32 +: 32] = s_hi[i];
            v_sl[i*32 +: 32] = s_lo[i];
            v_ct[i*32 +: 32] = ctl[i];
            v_tl[i*32 +: 32] = t_lo[i];
            v_th[i*32 +: 32] = t_hi[i];
        end
    end

    ileave_target_sel #(.NUM_SLOTS(NS)) i_ileave_target_sel (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .slot_base_hi(v_bh), .slot_base_lo(v_bl), .slot_size_hi(v_sh),
        .slot_size_lo(v_sl), .slot_ctrl(v_ct), .slot_tgt_lo(v_tl),
        .slot_tgt_hi(v_th), .rsp_valid(rsp_valid), .rsp_found(rsp_found),
        .rsp_target(rsp_target)
    );

    // Behavioural model of one lookup
    task automatic model(output logic f, output logic [7:0] t);
        f = 1'b0;
        t = 8'd0;
        for (int i = 0; i < NS; i++) begin
            logic [64:0] base, size, a;
            int iw, ig, idx;
            logic [63:0] q;
            base = {1'b0, b_hi[i], b_lo[i][31:28], 28'h0};
            size = {1'b0, s_hi[i], s_lo[i][31:28], 28'h0};
            a = {1'b0, req_addr};
            if (a >= base && a < base + size) begin
                if (!ctl[i][8]) return;
                iw = int'(ctl[i][7:4]);
                ig = int'(ctl[i][3:0]);
                if (iw > 3) return;
                q = req_addr / (64'd256 << ig);
                idx = int'(q % (64'd1 << iw));
                if (idx < 4) t = 8'((t_lo[i] >> (idx*8)) & 32'hFF);
                else         t = 8'((t_hi[i] >> ((idx-4)*8)) & 32'hFF);
                f = 1'b1;
                return;
            end
        end
    endtask

    task automatic step(input string tag);
        logic f;
        logic [7:0] t;
        model(f, t);
        if (rst) begin
            exp_valid = 0; exp_found = 0; exp_target = 0;
        end else begin
            exp_valid = req_valid;
            exp_found = req_valid & f;
            exp_target = (req_valid & f) ? t : 8'd0;
        end
        cur_tag = tag;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== exp_valid || rsp_found !== exp_found || rsp_target !== exp_target) begin
            fails++;
            $display("FAIL %s: actual v=%0b f=%0b t=%02h expected v=%0b f=%0b t=%02h",
                     cur_tag, rsp_valid, rsp_found, rsp_target, exp_valid, exp_found, exp_target);
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NS; i++) begin
            b_hi[i] = 0; b_lo[i] = 0; s_hi[i] = 0; s_lo[i] = 0;
            ctl[i] = 0; t_lo[i] = 0; t_hi[i] = 0;
        end
    endtask

    task automatic lookup(input logic [63:0] a, input string tag);
        req_valid = 1'b1;
        req_addr = a;
        step(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R10: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        clear_slots();
        b_hi[0] = 32'h1; s_lo[0] = 32'h1000_0000; ctl[0] = 32'h100;
        t_lo[0] = 32'h4433_2211; t_hi[0] = 32'h8877_6655;
        req_valid = 1'b1;
        req_addr = 64'h1_0000_0000;
        step("R1 in reset");
        step("R1 in reset");
        rst = 1'b0;
        req_valid = 1'b0;
        step("R1 after reset");

        lookup(64'h1_0000_0000, "R4 IW0");
        ctl[0] = 32'h110;
        lookup(64'h1_0000_0100, "R4 IW1 idx1");
        lookup(64'h1_0000_0200, "R4 IW1 wraps");
        ctl[0] = 32'h130;
        lookup(64'h1_0000_0500, "R5 idx5 high word");
        lookup(64'h1_0000_0300, "R5 idx3 low word");
        lookup(64'h1_0000_0700, "R5 idx7");
        ctl[0] = 32'h122;
        lookup(64'h1_0000_0C00, "R4 IG2 IW2");
        lookup(64'h1_0000_0BFF, "R4 IG2 boundary");
        ctl[0] = 32'h100;
        lookup(64'h0_FFFF_FFFF, "R2 below base");
        lookup(64'h1_0FFF_FFFF, "R2 last byte");
        lookup(64'h1_1000_0000, "R2 end exclusive");
        s_lo[0] = 0;
        lookup(64'h1_0000_0000, "R2 size zero");
        s_lo[0] = 32'h1FFF_FFFF; b_lo[0] = 32'h0FFF_FFFF;
        lookup(64'h1_0000_0000, "R3 low bits ignored");
        lookup(64'h1_1000_0000, "R3 size masked");

        b_hi[1] = 32'h1; s_lo[1] = 32'h2000_0000; ctl[1] = 32'h100;
        t_lo[1] = 32'hAABB_CCDD; t_hi[1] = 32'h0102_0304;
        lookup(64'h1_0000_0040, "R6 slot0 wins");
        lookup(64'h1_1800_0000, "R6 only slot1");
        ctl[0] = 32'h000;
        lookup(64'h1_0000_0040, "R7 uncommitted first");
        lookup(64'h1_1800_0000, "R7 later slot alone");
        ctl[0] = 32'h140;
        lookup(64'h1_0000_0040, "R8 IW4");
        ctl[0] = 32'h1F0;
        lookup(64'h1_0000_0040, "R8 IW15");
        lookup(64'h5_0000_0000, "R9 no match");
        req_valid = 1'b0;
        req_addr = 64'h1_1800_0000;
        step("R10 idle");
        lookup(64'h1_1800_0000, "R10 back to back");
        lookup(64'h1_1800_0100, "R10 back to back");

        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NS; i++) begin
                b_hi[i] = ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h0;
                b_lo[i] = $urandom;
                s_hi[i] = 0;
                s_lo[i] = $urandom;
                ctl[i] = 32'h100 | ($urandom & 32'h7F);
                if ($urandom_range(0, 5) == 0) ctl[i] = ctl[i] & ~32'h100;
                t_lo[i] = $urandom;
                t_hi[i] = $urandom;
            end
            req_valid = ($urandom_range(0, 7) != 0);
            req_addr = {31'h0, 1'($urandom_range(0, 3) == 0), 32'($urandom)};
            step("R4 R5 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule